// File: doc/BRIEF.md
# Carry-Save Radix-2 Square Root Extractor

This unit extracts the square root of a normalized fractional radicand, one root digit per clock. Each digit is taken from {-1, 0, +1}. The working remainder is never fully added up while the loop runs. It stays in two registers, a sum word and a carry word. Each step looks only at a short assimilated window of their top bits to pick the next digit. Because a zero digit is allowed, the digit regions overlap near zero, so the exact sign of the remainder is never needed. When the digit is zero, the step only shifts the remainder.

The root is built on the fly in two registers: the current root Q and Q minus one unit in the last place. The subtrahend for a +1 digit uses Q, the subtrahend for a -1 digit uses Q−1, and each has a short bit pattern appended at the current digit position. After the last digit, one full addition gives the remainder. If that remainder is negative, the root is replaced by the Q−1 register and the remainder is corrected. The results are the floor square root and a non-negative remainder.

The radicand is `2N` bits with value `radicand / 2^(2N)`, in [1/4, 1). The root is `N` bits with value `root / 2^N`.

Top module: `csa_sqrt`

## Requirements
- R1: For every radicand in [2^(2N-2), 2^(2N)), the root output on completion equals floor(sqrt(radicand)) taken as an integer.
- R2: On completion the remainder output equals radicand − root², and it lies in [0, 2·root].
- R3: On completion the most significant root bit is 1.
- R4: `done` rises on the (N+2)-th rising clock edge, counting the edge that samples `start` as the first, and it stays high for exactly one cycle.
- R5: A `start` pulse arriving while an extraction is in progress is ignored, and so is a change of `radicand` after it has been sampled. The running result is unaffected and `done` fires only once.
- R6: `root` and `rem` hold their values between completions, whatever happens on `radicand`.
- R7: The first root digit is always +1.
- R8: A step with digit 0 only doubles the remainder: both the sum and carry words shift left by one with nothing added.
- R9: After reset `done`, `root` and `rem` are all 0.
- R10: When the raw root overshoots, it is decremented by one unit. With N=7 and radicand 7808 (61/128), the raw root 89 becomes root 88 and the remainder becomes 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an extraction; sampled only while idle |
| radicand | input | 2N | Fractional radicand, value radicand/2^(2N) |
| root | output | N | Floor root, value root/2^N |
| rem | output | N+1 | Integer remainder radicand − root² |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check that the first digit is forced to +1, that a zero-digit step is a pure shift of both remainder words, and that the assimilated final remainder has no fractional residue and stays within its magnitude bound. They also check that `done` is a single-cycle pulse, that the outputs change only with `done`, and that every completed result is normalized with a remainder no larger than twice the root. Only the bench's scenarios can show that each root really is the floor square root and each remainder the exact difference. For this it sweeps every legal radicand of a 7-bit-root configuration. The bench also covers the completion latency, the example that needs the negative-remainder correction, and the cases where a mid-run start or radicand change is ignored.

// File: rtl/csa_sqrt.sv
module csa_sqrt #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2*N-1:0]   radicand,
  output logic [N-1:0]     root,
  output logic [N:0]       rem,
  output logic             done
);
  localparam int XW = 2 * N;
  localparam int W  = XW + 4;
  localparam int CW = $clog2(N + 1);
  localparam logic [W-1:0] ONEW = {{(W-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] ONEN = {{(N-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;
  st_t st;

  logic [W-1:0]  ws, wc;
  logic [N-1:0]  qa, qb;
  logic [CW-1:0] step;

  logic [W-1:0]  s2, c2, ulp, dmul, dop, ns, nc, wfull;
  logic [N-1:0]  qbit;
  logic signed [6:0] est;
  logic qp, qn, running, fin;

  assign running = (st == RUN);
  assign fin     = (st == FIN);

  assign s2  = ws << 1;
  assign c2  = wc << 1;
  assign est = s2[W-1 -: 7] + c2[W-1 -: 7];

  assign qp = (step == CW'(1)) || (est >= 7'sd4);
  assign qn = (step != CW'(1)) && (est < -7'sd4);

  assign ulp  = ONEW << (XW - int'(step));
  assign qbit = ONEN << (N - int'(step));

  assign dmul = qp ? (({{(W-N){1'b0}}, qa} << (N + 1)) | ulp)
                   : (({{(W-N){1'b0}}, qb} << (N + 1)) | ulp | (ulp << 1));
  assign dop  = qp ? ~dmul : dmul;

  assign ns = s2 ^ c2 ^ dop;
  assign nc = (((s2 & c2) | (s2 & dop) | (c2 & dop)) << 1) | {{(W-1){1'b0}}, qp};

  assign wfull = ws + wc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      ws   <= '0;
      wc   <= '0;
      qa   <= '0;
      qb   <= '0;
      step <= '0;
      root <= '0;
      rem  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          ws   <= {4'b0000, radicand};
          wc   <= '0;
          qa   <= '0;
          qb   <= '0;
          step <= CW'(1);
          st   <= RUN;
        end
        RUN: begin
          if (qp || qn) begin
            ws <= ns;
            wc <= nc;
          end else begin
            ws <= s2;
            wc <= c2;
          end
          if (qp) begin
            qa <= qa | qbit;
            qb <= qa;
          end else if (qn) begin
            qa <= qb | qbit;
          end else begin
            qb <= qb | qbit;
          end
          if (step == CW'(N)) st <= FIN;
          else step <= step + CW'(1);
        end
        FIN: begin
          if (wfull[W-1]) begin
            root <= qb;
            rem  <= wfull[N +: N+1] + {qb, 1'b1};
          end else begin
            root <= qa;
            rem  <= wfull[N +: N+1];
          end
          done <= 1'b1;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csa_sqrt_chk.sv
module csa_sqrt_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done,
  input logic [N-1:0]         root,
  input logic [N:0]           rem,
  input logic                 running,
  input logic                 fin,
  input logic [$clog2(N+1)-1:0] step,
  input logic                 qp,
  input logic                 qn,
  input logic [2*N+3:0]       ws,
  input logic [2*N+3:0]       wc,
  input logic [2*N+3:0]       wfull
);
  localparam int XW = 2 * N;
  localparam int W  = XW + 4;

  assert_first_digit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && step == 1) |-> (qp && !qn));

  assert_zero_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !qp && !qn) |=> (ws == ($past(ws) << 1) && wc == ($past(wc) << 1)));

  assert_digit_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> $onehot0({qp, qn}));

  assert_exact_residue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (wfull[N-1:0] == '0));

  assert_residue_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (wfull[W-1:XW+1] == '0 || wfull[W-1:XW+1] == '1));

  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem <= {root, 1'b0}));

  assert_normalized_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> root[N-1]);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_root_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(root) |-> done);

  assert_hold_rem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rem) |-> done);
endmodule

bind csa_sqrt csa_sqrt_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .root(root), .rem(rem),
  .running(running), .fin(fin), .step(step), .qp(qp), .qn(qn),
  .ws(ws), .wc(wc), .wfull(wfull)
);

// File: tb/test_csa_sqrt.sv
module test_csa_sqrt;
  localparam int N  = 7;
  localparam int XW = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [XW-1:0] radicand = '0;
  logic [N-1:0]  root;
  logic [N:0]    rem;
  logic          done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  csa_sqrt #(.N(N)) i_csa_sqrt (
    .clk(clk), .rst_n(rst_n), .start(start), .radicand(radicand),
    .root(root), .rem(rem), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(input int x, output int lat);
    @(negedge clk);
    radicand = XW'(x);
    start = 1'b1;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      #1 start = 1'b0;
    end while (!done && lat < 40);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R4 watchdog actual=hang expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat, e, x, r0, m0, dn;
    repeat (3) @(posedge clk);
    #1;
    chk(done == 0, "R9 done", int'(done), 0);
    chk(root == 0, "R9 root", int'(root), 0);
    chk(rem == 0, "R9 rem", int'(rem), 0);
    @(negedge clk) rst_n = 1'b1;

    // R10: overshoot corrected, 61/128
    run_one(7808, lat);
    chk(root == 88, "R10 root", int'(root), 88);
    chk(rem == 64, "R10 rem", int'(rem), 64);
    chk(lat == N + 2, "R4 latency", lat, N + 2);
    @(posedge clk); #1;
    chk(done == 0, "R4 pulse width", int'(done), 0);

    // R6: outputs hold while radicand moves without start
    r0 = int'(root); m0 = int'(rem);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) radicand = XW'(4096 + 1111 * k);
    end
    @(posedge clk); #1;
    chk(int'(root) == r0, "R6 root", int'(root), r0);
    chk(int'(rem) == m0, "R6 rem", int'(rem), m0);

    // R5: mid-run start and radicand change ignored
    @(negedge clk);
    radicand = XW'(16383);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    dn = 0;
    for (int k = 0; k < 3; k++) @(negedge clk);
    radicand = XW'(4096);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (done) begin
        dn++;
        chk(root == 127, "R5 root", int'(root), 127);
        chk(rem == 254, "R5 rem", int'(rem), 254);
      end
    end
    chk(dn == 1, "R5 single done", dn, 1);

    // R1 R2 R3 R7 R8: full sweep of legal radicands
    e = 64;
    for (int xi = 4096; xi < 16384; xi++) begin
      x = xi;
      while ((e + 1) * (e + 1) <= x) e++;
      run_one(x, lat);
      chk(root == N'(e) && int'(rem) == x - e * e && root[N-1],
          "R1 R2 R3 R7 R8 sweep", int'(root) * 1000 + int'(rem), e * 1000 + (x - e * e));
      if (xi < 4112 || xi > 16370)
        chk(lat == N + 2, "R4 latency sweep", lat, N + 2);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule